// File: doc/BRIEF.md
# Task Ready-Table Scheduler Accelerator

This block is a stateful coprocessor meant to sit behind a soft processor's custom-instruction port. It keeps an RTOS ready table in its own registers, so the table never has to live in memory. Software issues one instruction with two operands. Operand A selects one of four commands and operand B carries a task priority. After one cycle the block raises done and presents a result word.

The table is a bitmap built from groups of eight tasks. Alongside it sits a summary vector with one bit per group, and each summary bit shows whether that group holds any ready task. The highest-priority ready task is found with a two-level lowest-set-bit search. The first level picks the lowest group whose summary bit is set. The second level picks the lowest set member inside that group. The number of groups is a build parameter, so storage is sized to the task count the application needs (2, 4 or 8 groups give 16, 32 or 64 tasks).

Top module: `sched_ready_accel`

## Requirements
- R1: After reset the table and summary are empty, done is low, and a find command returns all ones.
- R2: Operand A bits [1:0] select the command: 0 init, 1 set ready, 2 clear ready, 3 find. Set ready with priority p (operand B bits [5:0]) marks bit p mod 8 of group p div 8.
- R3: Clear ready with priority p removes only that task. All other ready tasks stay ready.
- R4: Init empties the entire table and the summary.
- R5: Find returns the lowest-numbered ready priority, computed as group*8 + member and zero-extended to the result width.
- R6: Find with no ready task returns a result of all ones.
- R7: A summary bit is set exactly when its group has a ready member. Clearing the last member of a group drops the bit in the same update, so a later find moves on to the next group.
- R8: A priority at or above the configured task count (NUM_GROUPS*8, 32 by default) is ignored by set and clear.
- R9: done is high for exactly the one cycle that follows each cycle in which start is high. The result of init, set and clear is zero.
- R10: A command issued in the cycle right after another command sees that command's table update.
- R11: Find leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, one command per high cycle |
| opa | input | DATA_W | Operand A, command in bits [1:0] |
| opb | input | DATA_W | Operand B, priority in bits [5:0] |
| result | output | DATA_W | Command result, valid while done is high |
| done | output | 1 | Completion pulse |

## Verification
Two functions can land in adjacent cycles: a table update (set, clear or init) and a find that reads the table in the very next cycle, with start held high across both. The bench drives set-then-find and clear-then-find pairs back to back. This includes clearing the only member of the lowest ready group, and the following find must move to the next group. Each find result is compared with a bench model that has already applied the preceding update. Random mixes from a fixed seed add many more adjacent pairs.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int PRIO_W   = 6;
  localparam int MEMBER_W = 3;
  localparam int GROUP_SZ = 8;

  typedef enum logic [1:0] {
    CMD_INIT = 2'd0,
    CMD_SET  = 2'd1,
    CMD_CLR  = 2'd2,
    CMD_FIND = 2'd3
  } sched_cmd_e;
endpackage

// File: rtl/sched_prio_decode.sv
module sched_prio_decode #(
  parameter int NUM_GROUPS = 4,
  localparam int GRP_W     = $clog2(NUM_GROUPS),
  localparam int NUM_TASKS = NUM_GROUPS * sched_pkg::GROUP_SZ
) (
  input  logic [sched_pkg::PRIO_W-1:0] prio,
  output logic [GRP_W-1:0]             grp,
  output logic [7:0]                   mem_oh,
  output logic                         in_range
);
  always_comb begin
    in_range = (7'(prio) < 7'(NUM_TASKS));
    grp      = prio[sched_pkg::MEMBER_W +: GRP_W];
    mem_oh   = 8'b1 << prio[sched_pkg::MEMBER_W-1:0];
  end
endmodule

// File: rtl/sched_lsb_find.sv
module sched_lsb_find #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/sched_ready_table.sv
module sched_ready_table
  import sched_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  localparam int GRP_W     = $clog2(NUM_GROUPS),
  localparam int NUM_TASKS = NUM_GROUPS * GROUP_SZ
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  sched_cmd_e            cmd,
  input  logic [GRP_W-1:0]      grp,
  input  logic [7:0]            mem_oh,
  input  logic                  in_range,
  output logic [NUM_TASKS-1:0]  ready_q,
  output logic [NUM_GROUPS-1:0] summary_q
);
  logic [NUM_TASKS-1:0]  ready_d;
  logic [NUM_GROUPS-1:0] summary_d;
  logic [7:0]            grp_after;
  logic                  tbl_en;

  always_comb begin
    ready_d   = ready_q;
    summary_d = summary_q;
    grp_after = ready_q[{grp, 3'b000} +: 8] & ~mem_oh;
    tbl_en    = 1'b0;
    if (wr_en) begin
      unique case (cmd)
        CMD_INIT: begin
          ready_d   = '0;
          summary_d = '0;
          tbl_en    = 1'b1;
        end
        CMD_SET: if (in_range) begin
          ready_d[{grp, 3'b000} +: 8] = ready_q[{grp, 3'b000} +: 8] | mem_oh;
          summary_d[grp]              = 1'b1;
          tbl_en                      = 1'b1;
        end
        CMD_CLR: if (in_range) begin
          ready_d[{grp, 3'b000} +: 8] = grp_after;
          summary_d[grp]              = |grp_after;
          tbl_en                      = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= '0;
      summary_q <= '0;
    end else if (tbl_en) begin
      ready_q   <= ready_d;
      summary_q <= summary_d;
    end
  end
endmodule

// File: rtl/sched_ready_accel.sv
module sched_ready_accel
  import sched_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_GROUPS = 4,
  localparam int GRP_W     = $clog2(NUM_GROUPS),
  localparam int NUM_TASKS = NUM_GROUPS * GROUP_SZ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  sched_cmd_e            cmd;
  logic [GRP_W-1:0]      dec_grp;
  logic [7:0]            dec_oh;
  logic                  dec_ok;
  logic [NUM_TASKS-1:0]  ready_q;
  logic [NUM_GROUPS-1:0] summary_q;
  logic [GRP_W-1:0]      win_grp;
  logic                  any_ready;
  logic [MEMBER_W-1:0]   win_mem;
  logic                  mem_any;
  logic [DATA_W-1:0]     result_d;
  logic [DATA_W-1:0]     result_q;
  logic                  done_q;

  assign cmd = sched_cmd_e'(opa[1:0]);

  sched_prio_decode #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
    .prio     (opb[PRIO_W-1:0]),
    .grp      (dec_grp),
    .mem_oh   (dec_oh),
    .in_range (dec_ok)
  );

  sched_ready_table #(.NUM_GROUPS(NUM_GROUPS)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (start),
    .cmd       (cmd),
    .grp       (dec_grp),
    .mem_oh    (dec_oh),
    .in_range  (dec_ok),
    .ready_q   (ready_q),
    .summary_q (summary_q)
  );

  sched_lsb_find #(.W(NUM_GROUPS)) u_grp_find (
    .vec (summary_q),
    .idx (win_grp),
    .any (any_ready)
  );

  sched_lsb_find #(.W(GROUP_SZ)) u_mem_find (
    .vec (ready_q[{win_grp, 3'b000} +: 8]),
    .idx (win_mem),
    .any (mem_any)
  );

  always_comb begin
    result_d = '0;
    if (cmd == CMD_FIND) begin
      if (any_ready && mem_any) result_d[GRP_W+MEMBER_W-1:0] = {win_grp, win_mem};
      else                      result_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= start;
      if (start) result_q <= result_d;
    end
  end

  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/sched_ready_chk.sv
module sched_ready_chk #(
  parameter int DATA_W     = 32,
  parameter int NUM_GROUPS = 4,
  localparam int NUM_TASKS = NUM_GROUPS * 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [DATA_W-1:0]     opa,
  input logic [DATA_W-1:0]     opb,
  input logic [DATA_W-1:0]     result,
  input logic                  done,
  input logic [NUM_TASKS-1:0]  ready_q,
  input logic [NUM_GROUPS-1:0] summary_q
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sum
    // R7
    summary_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      summary_q[g] == (|ready_q[g*8 +: 8]));
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R4
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opa[1:0] == 2'd0) |=> (ready_q == '0));

  // R6
  idle_find_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opa[1:0] == 2'd3 && ready_q == '0) |=> (&result));

  // R8
  range_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opa[1:0] != 2'd0 && 7'(opb[5:0]) >= 7'(NUM_TASKS)) |=> $stable(ready_q));

  // R11
  find_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opa[1:0] == 2'd3) |=> $stable(ready_q));
endmodule

bind sched_ready_accel sched_ready_chk #(.DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .opa       (opa),
  .opb       (opb),
  .result    (result),
  .done      (done),
  .ready_q   (ready_q),
  .summary_q (summary_q)
);

// File: tb/sched_ready_accel_test.sv
module sched_ready_accel_test;
  localparam int DATA_W = 32;
  localparam int NG     = 4;
  localparam int NT     = NG * 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [DATA_W-1:0] opa, opb;
  logic [DATA_W-1:0] result;
  logic              done;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit [63:0] mdl;

  sched_ready_accel #(.DATA_W(DATA_W), .NUM_GROUPS(NG)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
    .result(result), .done(done)
  );

  always #4 clk = ~clk;

  function automatic logic [DATA_W-1:0] exp_find(input bit [63:0] m);
    for (int i = 0; i < NT; i++) if (m[i]) return DATA_W'(i);
    return '1;
  endfunction

  function automatic bit [63:0] apply(input bit [63:0] m, input int c, input int p);
    bit [63:0] r = m;
    if (c == 0) r = '0;
    else if (c == 1 && p < NT) r[p] = 1'b1;
    else if (c == 2 && p < NT) r[p] = 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one command; sample at the negedge after the capturing edge.
  task automatic issue(input string req, input int c, input int p);
    logic [DATA_W-1:0] e;
    e = (c == 3) ? exp_find(mdl) : '0;
    start = 1'b1; opa = DATA_W'(c); opb = DATA_W'(p);
    @(negedge clk);
    start = 1'b0;
    mdl = apply(mdl, c, p);
    check({req, " done"}, {31'd0, done}, 32'd1);
    check({req, " result"}, result, e);
  endtask

  // Update command immediately followed by find (R10)
  task automatic pair(input string req, input int c, input int p);
    start = 1'b1; opa = DATA_W'(c); opb = DATA_W'(p);
    @(negedge clk);
    mdl = apply(mdl, c, p);
    opa = DATA_W'(3); opb = '0;
    @(negedge clk);
    start = 1'b0;
    check({req, " done"}, {31'd0, done}, 32'd1);
    check({req, " find"}, result, exp_find(mdl));
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; opa = '0; opb = '0; mdl = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done low", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    issue("R1 empty find", 3, 0);
    @(negedge clk);
    // R9: done drops when start idle
    check("R9 done single", {31'd0, done}, 32'd0);

    // R2 / R5: set and find
    issue("R2 set 13", 1, 13);
    issue("R5 find 13", 3, 0);
    issue("R2 set 31", 1, 31);
    issue("R2 set 9", 1, 9);
    issue("R5 find 9", 3, 0);
    // R3: clear one, others stay
    issue("R3 clear 9", 2, 9);
    issue("R3 find 13", 3, 0);
    // R8: out-of-range ignored
    issue("R8 set 40", 1, 40);
    issue("R8 find after set 40", 3, 0);
    issue("R8 clear 63", 2, 63);
    issue("R11 find repeat", 3, 0);
    // R7 / R10: clear last member of group 1, find moves on to group 3
    pair("R7 R10 clear 13", 2, 13);
    pair("R10 set 0", 1, 0);
    pair("R10 clear 0", 2, 0);
    // R4: init
    issue("R4 init", 0, 0);
    issue("R6 find empty", 3, 0);
    pair("R4 R10 init", 0, 0);

    // random mix, includes back-to-back pairs
    for (int k = 0; k < 400; k++) begin
      int c, p, w;
      w = int'($urandom_range(0, 19));
      c = (w == 0) ? 0 : (w < 8) ? 1 : (w < 13) ? 2 : 3;
      p = int'($urandom_range(0, 63));
      if ($urandom_range(0, 3) == 0) pair("R10 rand", c, p);
      else                           issue("R5 rand", c, p);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule